// File: doc/BRIEF.md
# Three-Level Reset Controller for a Card Interface

This block generates the reset controls for a memory-card host controller at three scopes. An external active-low reset pin is filtered so that only a long enough low level starts a full reset. This reset clears the configuration registers, the internal state machines and both data buffers, and it returns the host bus width to 16 bits. Two self-clearing trigger bits, written through a small register port, start narrower resets. The first resets the internal logic together with the buffers and leaves the configuration registers alone. The second clears only the receive and transmit buffers.

Each scope has its own active-low reset output. An output asserts at once when its cause appears. It releases on the clock a fixed number of stages after the cause ends. A buffer clear issued while a serial data transfer is running also sends a one-cycle abort pulse to the serial engine.

The register port takes 3-bit writes. Bit 0 is the bus width, with 1 meaning 16-bit and 0 meaning 8-bit. Bit 1 triggers the logic reset and bit 2 triggers the buffer clear. A read returns the width in bit 0 and zeros in bits 2:1.

Top module: `card_reset_ctrl`

## Requirements
- R1: A low level on `extRstN` that lasts fewer than MIN_LOW clock cycles (MIN_LOW = CLK_HZ × MIN_LOW_US / 10^6) asserts no reset output and leaves `busWide16` unchanged.
- R2: When `extRstN` stays low for MIN_LOW cycles or more, `regRstN`, `logicRstN`, `rxBufRstN` and `txBufRstN` are all low, `xferAbort` is 0 and `busWide16` is 1.
- R3: Every reset output goes low in the same cycle its cause appears. After the cause is removed it stays low for SYNC_STAGES-1 more clock edges and rises at the SYNC_STAGES-th edge.
- R4: A write with bit 1 set drives `logicRstN`, `rxBufRstN` and `txBufRstN` low. `regRstN` stays high and the width keeps the value written in bit 0.
- R5: A write with bit 2 set and bit 1 clear drives `rxBufRstN` and `txBufRstN` low in the same cycle, while `regRstN` and `logicRstN` stay high.
- R6: A write with bit 2 set while `xferBusy` is 1 produces `xferAbort` = 1 for exactly the one cycle after the write edge. The same write with `xferBusy` at 0 produces no pulse.
- R7: A trigger holds its cause for PULSE_CYCLES edges, so its outputs rise PULSE_CYCLES+SYNC_STAGES edges after the write edge. `ctlRdData` bits 2:1 always read 0.
- R8: Every write loads bit 0 into the width (1 = 16-bit, 0 = 8-bit), shown on `busWide16` and on `ctlRdData` bit 0 after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| extRstN | input | 1 | Raw external reset pin, active low, asynchronous |
| ctlWrEn | input | 1 | Register write strobe |
| ctlWrData | input | 3 | Write data: bit0 width, bit1 logic reset, bit2 buffer clear |
| ctlRdData | output | 3 | Read data: bit0 width, bits 2:1 zero |
| xferBusy | input | 1 | Serial engine has a data transfer in progress |
| regRstN | output | 1 | Configuration register reset, active low |
| logicRstN | output | 1 | State machine reset, active low |
| rxBufRstN | output | 1 | Receive buffer clear, active low |
| txBufRstN | output | 1 | Transmit buffer clear, active low |
| xferAbort | output | 1 | One-cycle abort pulse to the serial engine |
| busWide16 | output | 1 | 1 = 16-bit host bus, 0 = 8-bit |

## Verification
The hardest condition to reach from the ports is the low-time filter. At a realistic clock, 1 ms is hundreds of thousands of cycles, so the bench lowers the clock-frequency parameter until the limit becomes 20 cycles. It then drives one pin pulse well short of that limit and one well past it. After a short pulse it checks that a width of 8 bits written beforehand survives. A buffer clear that lands on a running transfer is reached by raising `xferBusy` in the same cycle as the write, and the bench checks that the abort pulse has gone by the following cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic hwReq;     // filtered external reset held
    logic softReq;   // logic-level reset pulse active
    logic bufReq;    // buffer-only clear pulse active
    logic abortHit;  // buffer clear written during a transfer
    logic widthWr;   // register write this cycle
    logic widthVal;  // width bit being written
  } rstStrobes_t;
endpackage

// File: rtl/rstc_ctl.sv
module rstc_ctl
  import rstc_pkg::*;
#(
  parameter int CLK_HZ       = 250_000_000,
  parameter int MIN_LOW_US   = 1000,
  parameter int PULSE_CYCLES = 4,
  parameter int PIN_SYNC     = 2
) (
  input  logic        clk,
  input  logic        extRstN,
  input  logic        ctlWrEn,
  input  logic [2:0]  ctlWrData,
  input  logic        xferBusy,
  output rstStrobes_t strobes
);
  localparam int MIN_LOW = (CLK_HZ / 1000) * MIN_LOW_US / 1000;
  localparam int CW      = $clog2(MIN_LOW + 1);
  localparam int PW      = $clog2(PULSE_CYCLES + 1);
  localparam int TRIGS   = 2;

  logic [PIN_SYNC-1:0] pinPipe;
  logic [CW-1:0]       lowCnt;
  logic                hwHold;
  logic                pinLow;
  logic [TRIGS-1:0]    trigActive;

  // pin high clears the filter at once; a low must be seen continuously
  always_ff @(posedge clk or posedge extRstN) begin
    if (extRstN) pinPipe <= '1;
    else         pinPipe <= {pinPipe[PIN_SYNC-2:0], 1'b0};
  end

  assign pinLow = !pinPipe[PIN_SYNC-1];

  always_ff @(posedge clk or posedge extRstN) begin
    if (extRstN) begin
      lowCnt <= '0;
      hwHold <= 1'b0;
    end else if (pinLow && !hwHold) begin
      if (lowCnt == CW'(MIN_LOW - 1)) hwHold <= 1'b1;
      lowCnt <= lowCnt + CW'(1);
    end
  end

  // self-clearing trigger bits: index 0 = logic reset (bit1), 1 = buffer clear (bit2)
  for (genvar g = 0; g < TRIGS; g++) begin : gTrig
    logic [PW-1:0] cnt;
    always_ff @(posedge clk or posedge hwHold) begin
      if (hwHold)                        cnt <= '0;
      else if (ctlWrEn && ctlWrData[g+1]) cnt <= PW'(PULSE_CYCLES);
      else if (cnt != '0)                cnt <= cnt - PW'(1);
    end
    assign trigActive[g] = (cnt != '0);
  end

  always_comb begin
    strobes.hwReq    = hwHold;
    strobes.softReq  = trigActive[0];
    strobes.bufReq   = trigActive[1];
    strobes.abortHit = ctlWrEn && ctlWrData[2] && xferBusy;
    strobes.widthWr  = ctlWrEn;
    strobes.widthVal = ctlWrData[0];
  end
endmodule

// File: rtl/rstc_dp.sv
module rstc_dp
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  rstStrobes_t strobes,
  output logic        regRstN,
  output logic        logicRstN,
  output logic        bufRstN,
  output logic        xferAbort,
  output logic        busWide16
);
  localparam int DOMAINS = 3;

  logic [DOMAINS-1:0] cause;
  logic [DOMAINS-1:0] relN;

  // nested scopes: registers < logic < buffers
  assign cause[0] = strobes.hwReq;
  assign cause[1] = cause[0] | strobes.softReq;
  assign cause[2] = cause[1] | strobes.bufReq;

  for (genvar d = 0; d < DOMAINS; d++) begin : gDom
    logic                   causeHere;
    logic [SYNC_STAGES-1:0] chain;
    assign causeHere = cause[d];
    always_ff @(posedge clk or posedge causeHere) begin
      if (causeHere) chain <= '0;
      else           chain <= {chain[SYNC_STAGES-2:0], 1'b1};
    end
    assign relN[d] = chain[SYNC_STAGES-1];
  end

  assign regRstN   = relN[0];
  assign logicRstN = relN[1];
  assign bufRstN   = relN[2];

  always_ff @(posedge clk or posedge strobes.hwReq) begin
    if (strobes.hwReq) begin
      busWide16 <= 1'b1;
      xferAbort <= 1'b0;
    end else begin
      if (strobes.widthWr) busWide16 <= strobes.widthVal;
      xferAbort <= strobes.abortHit;
    end
  end
endmodule

// File: rtl/card_reset_ctrl.sv
module card_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int CLK_HZ       = 250_000_000,
  parameter int MIN_LOW_US   = 1000,
  parameter int PULSE_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       extRstN,
  input  logic       ctlWrEn,
  input  logic [2:0] ctlWrData,
  output logic [2:0] ctlRdData,
  input  logic       xferBusy,
  output logic       regRstN,
  output logic       logicRstN,
  output logic       rxBufRstN,
  output logic       txBufRstN,
  output logic       xferAbort,
  output logic       busWide16
);
  rstStrobes_t strobes;
  logic        bufRstN;

  rstc_ctl #(
    .CLK_HZ(CLK_HZ), .MIN_LOW_US(MIN_LOW_US),
    .PULSE_CYCLES(PULSE_CYCLES), .PIN_SYNC(SYNC_STAGES)
  ) uCtl (
    .clk(clk), .extRstN(extRstN), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .xferBusy(xferBusy), .strobes(strobes)
  );

  rstc_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .strobes(strobes), .regRstN(regRstN),
    .logicRstN(logicRstN), .bufRstN(bufRstN),
    .xferAbort(xferAbort), .busWide16(busWide16)
  );

  // both buffers leave reset from one flop, so they always move together
  assign rxBufRstN = bufRstN;
  assign txBufRstN = bufRstN;
  assign ctlRdData = {2'b00, busWide16};
endmodule

// File: rtl/card_reset_ctrl_chk.sv
module card_reset_ctrl_chk (
  input logic       clk,
  input logic       extRstN,
  input logic       ctlWrEn,
  input logic [2:0] ctlWrData,
  input logic       xferBusy,
  input logic       regRstN,
  input logic       logicRstN,
  input logic       rxBufRstN,
  input logic       xferAbort,
  input logic       busWide16
);
  // armed once a genuine external reset has been seen
  logic armed;
  initial armed = 1'b0;
  always @(posedge clk) armed <= armed | (!regRstN && !extRstN);

  AST_FULL_WIDTH_DEFAULT: assert property (@(posedge clk) disable iff (!armed)
    $fell(regRstN) |-> busWide16);                                   // R2
  AST_REG_IMPLIES_LOGIC: assert property (@(posedge clk) disable iff (!armed)
    !regRstN |-> !logicRstN);                                        // R2
  AST_SOFT_KEEPS_REGS: assert property (@(posedge clk) disable iff (!armed)
    (ctlWrEn && ctlWrData[1] && regRstN && extRstN) |=> regRstN);    // R4
  AST_LOGIC_IMPLIES_BUF: assert property (@(posedge clk) disable iff (!armed)
    !logicRstN |-> !rxBufRstN);                                      // R5
  AST_BUF_KEEPS_LOGIC: assert property (@(posedge clk) disable iff (!armed)
    (ctlWrEn && ctlWrData[2] && !ctlWrData[1] && logicRstN && extRstN) |=> logicRstN); // R5
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!armed || !regRstN)
    xferAbort |-> $past(ctlWrEn && ctlWrData[2] && xferBusy));       // R6
endmodule

bind card_reset_ctrl card_reset_ctrl_chk uChk (.*);

// File: tb/tb_card_reset_ctrl.sv
`timescale 1ns/1ps
module tb_card_reset_ctrl;
  localparam int CLK_HZ  = 20000;
  localparam int LOW_US  = 1000;
  localparam int PULSE   = 4;
  localparam int SYNC    = 2;
  localparam int MIN_LOW = 20;

  logic       clk = 1'b0;
  logic       extRstN, ctlWrEn, xferBusy;
  logic [2:0] ctlWrData, ctlRdData;
  logic       regRstN, logicRstN, rxBufRstN, txBufRstN, xferAbort, busWide16;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  card_reset_ctrl #(.CLK_HZ(CLK_HZ), .MIN_LOW_US(LOW_US),
                    .PULSE_CYCLES(PULSE), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .extRstN(extRstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .xferBusy(xferBusy), .regRstN(regRstN),
    .logicRstN(logicRstN), .rxBufRstN(rxBufRstN), .txBufRstN(txBufRstN),
    .xferAbort(xferAbort), .busWide16(busWide16));

  always #2 clk = ~clk;

  // output order: reg, logic, rx, tx, abort, width
  function automatic logic [5:0] outs();
    return {regRstN, logicRstN, rxBufRstN, txBufRstN, xferAbort, busWide16};
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [2:0] d, logic b);
    @(negedge clk);
    ctlWrData = d; xferBusy = b; ctlWrEn = 1'b1;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (PULSE + SYNC + 3) @(negedge clk);
    xferBusy = 1'b0;
  endtask

  // {wrData, busy, expected outputs}
  localparam logic [9:0] VEC [0:7] = '{
    {3'b000, 1'b0, 6'b111100},  // R8 width to 8-bit
    {3'b001, 1'b0, 6'b111101},  // R8 width to 16-bit
    {3'b011, 1'b0, 6'b100001},  // R4 logic reset keeps regs
    {3'b101, 1'b0, 6'b110001},  // R5 buffer clear only, no abort
    {3'b101, 1'b1, 6'b110011},  // R6 abort during transfer
    {3'b010, 1'b1, 6'b100000},  // R4 with width 0, no abort
    {3'b100, 1'b1, 6'b110010},  // R6 abort, width 0 kept
    {3'b001, 1'b0, 6'b111101}   // R8 restore
  };

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    extRstN = 1'b1; ctlWrEn = 1'b0; ctlWrData = 3'b000; xferBusy = 1'b0;
    repeat (5) @(negedge clk);

    // R2 full reset and reset state
    extRstN = 1'b0;
    repeat (MIN_LOW + 8) @(negedge clk);
    chk("R2 reset state", outs(), 6'b000001);
    chk("R7 readback in reset", {3'b000, ctlRdData}, 6'b000001);
    extRstN = 1'b1;
    @(negedge clk);
    chk("R3 release delayed", outs(), 6'b000001);
    @(negedge clk);
    chk("R3 release after sync", outs(), 6'b111101);

    // vector table
    for (int i = 0; i < 8; i++) begin
      doWrite(VEC[i][9:7], VEC[i][6]);
      chk("R4/R5/R6/R8 vector", outs(), VEC[i][5:0]);
      chk("R7 R8 readback", {3'b000, ctlRdData}, {5'b00000, VEC[i][0]});
      settle();
      chk("R3 vector recovered", outs(), {5'b11110, VEC[i][0]});
    end

    // R7 pulse length of a logic reset
    doWrite(3'b011, 1'b0);
    repeat (PULSE + 1) @(negedge clk);
    chk("R7 still held", outs(), 6'b100001);
    @(negedge clk);
    chk("R7 released", outs(), 6'b111101);

    // R6 abort lasts one cycle
    doWrite(3'b101, 1'b1);
    chk("R6 abort high", outs(), 6'b110011);
    @(negedge clk);
    chk("R6 abort one cycle", outs(), 6'b110001);
    settle();

    // R1 short pulse ignored, 8-bit width kept
    doWrite(3'b000, 1'b0);
    settle();
    extRstN = 1'b0;
    repeat (MIN_LOW / 2) @(negedge clk);
    extRstN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 short pulse ignored", outs(), 6'b111100);

    // R2 long pulse restores 16-bit width
    extRstN = 1'b0;
    repeat (MIN_LOW + 8) @(negedge clk);
    chk("R2 long pulse", outs(), 6'b000001);
    extRstN = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    chk("R2 after release", outs(), 6'b111101);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule